// File: doc/BRIEF.md
# Selectable-Edge Timer Counter

An 8-bit free-running counter that sits on a register bus as an ordinary readable and writable register. A control register picks what advances it. The choices are the internal instruction-cycle strobe or a chosen transition on an external pin. A separate bit picks whether a rising or a falling transition on that pin counts. When the count wraps from all-ones to zero, a sticky overflow flag is set, and it stays set until software clears it.

The external pin goes through a two-flop synchroniser and an edge detector. Every qualifying edge is held in a one-deep pending latch until the next instruction-cycle strobe, so the counter advances at most once per instruction cycle. A strap input marks the shared pin as general-purpose I/O. While it is high, the counter falls back to the instruction clock whatever the control register holds.

Top module: `sel_edge_timer`

## Requirements
- R1: After reset the counter reads 0, the control register reads 0 and the overflow flag is 0.
- R2: With the source-select bit (control address 1, bit 0) at 0, the counter advances by exactly one on each clock in which `cycleEn` is high, and holds otherwise.
- R3: With source-select at 1 and edge-select (control address 1, bit 1) at 0, a low-to-high transition on `extPin` advances the counter by one at the next instruction-cycle strobe, and a high-to-low transition does not count.
- R4: With source-select at 1 and edge-select at 1, a high-to-low transition counts and a low-to-high transition does not.
- R5: The counter never advances in a clock without `cycleEn`. Several qualifying pin edges between two strobes produce a single count.
- R6: A bus write to address 0 loads the counter, and the value reads back at address 0. A write in the same clock as an increment wins, and the written value is kept without the increment.
- R7: An increment from 0xFF to 0x00 sets the overflow flag (address 2, bit 0, also on `ovfFlag`). The flag stays set through later counts and through a status write with bit 0 at 0. A status write with bit 0 at 1 clears it.
- R8: While `gpioMode` is high, the pin is ignored and the counter advances on `cycleEn` even if source-select is 1.
- R9: The control register keeps only bits 1:0. Its other bits read 0, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycleEn | input | 1 | One-clock strobe per instruction cycle |
| extPin | input | 1 | External count pin, asynchronous |
| gpioMode | input | 1 | Shared pin used as general I/O; forces internal source |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address: 0 count, 1 control, 2 status |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for `busAddr` (combinational) |
| ovfFlag | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that the bus inputs, `cycleEn` and `gpioMode` are driven to defined levels from reset onward. The bench drives all of them low before reset is released and changes them only at falling clock edges. The pin checks assume that `extPin` holds each level for longer than the synchroniser depth. The bench therefore waits four clocks after every pin change before it strobes `cycleEn` or changes the pin again. Write-priority and wrap behaviour are checked by driving a bus write and a strobe in the same clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_COUNT = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic incEn;
    logic loadEn;
    logic clrFlag;
  } tmr_strobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycleEn,
  input  logic              extPin,
  input  logic              gpioMode,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        ctrlBits,
  output tmr_strobe_t       strobe,
  output logic              srcSel,
  output logic              edgeSel
);
  // synchroniser stages plus one history flop for edge detection
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] syncReg;
  logic syncNow, syncPrev, extMode, edgeSeen, pending;

  always_ff @(posedge clk) begin
    if (!rstN) syncReg <= '0;
    else       syncReg <= {syncReg[CHAIN-2:0], extPin};
  end

  assign syncNow  = syncReg[SYNC_STAGES-1];
  assign syncPrev = syncReg[SYNC_STAGES];
  assign extMode  = srcSel & ~gpioMode;
  assign edgeSeen = extMode & (edgeSel ? (syncPrev & ~syncNow)
                                       : (~syncPrev & syncNow));

  // one-deep latch: edges between strobes collapse into one count
  always_ff @(posedge clk) begin
    if (!rstN) pending <= 1'b0;
    else       pending <= extMode & (pending | edgeSeen) & ~cycleEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcSel  <= 1'b0;
      edgeSel <= 1'b0;
    end else if (busWrEn && busAddr == ADDR_CTRL) begin
      srcSel  <= ctrlBits[0];
      edgeSel <= ctrlBits[1];
    end
  end

  always_comb begin
    strobe.loadEn  = busWrEn && (busAddr == ADDR_COUNT);
    strobe.clrFlag = busWrEn && (busAddr == ADDR_STAT) && ctrlBits[0];
    strobe.incEn   = cycleEn && (extMode ? (pending | edgeSeen) : 1'b1);
  end

  p_inc_on_cycle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !cycleEn |-> !strobe.incEn);

  p_pin_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    gpioMode |-> (strobe.incEn == cycleEn));

  p_ctrl_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_CTRL) |=>
      (srcSel == $past(ctrlBits[0]) && edgeSel == $past(ctrlBits[1])));
endmodule

// File: rtl/tmr_dp.sv
module tmr_dp
  import tmr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmr_strobe_t      strobe,
  input  logic [WIDTH-1:0] loadVal,
  output logic [WIDTH-1:0] count,
  output logic             ovfFlag
);
  localparam logic [WIDTH-1:0] MAX_VAL = {WIDTH{1'b1}};

  logic wrapNow;
  assign wrapNow = strobe.incEn && !strobe.loadEn && (count == MAX_VAL);

  always_ff @(posedge clk) begin
    if (!rstN)              count <= '0;
    else if (strobe.loadEn) count <= loadVal;
    else if (strobe.incEn)  count <= count + 1'b1;
  end

  // a wrap in the same clock as a clear leaves the flag set
  always_ff @(posedge clk) begin
    if (!rstN)               ovfFlag <= 1'b0;
    else if (wrapNow)        ovfFlag <= 1'b1;
    else if (strobe.clrFlag) ovfFlag <= 1'b0;
  end

  p_write_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadEn |=> count == $past(loadVal));

  p_step_one_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incEn && !strobe.loadEn) |=> count == $past(count) + 1'b1);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.incEn && !strobe.loadEn) |=> $stable(count));

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !strobe.clrFlag) |=> ovfFlag);

  p_flag_on_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> ($past(count) == MAX_VAL && count == '0));
endmodule

// File: rtl/sel_edge_timer.sv
module sel_edge_timer
  import tmr_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycleEn,
  input  logic              extPin,
  input  logic              gpioMode,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WIDTH-1:0]  busWrData,
  output logic [WIDTH-1:0]  busRdData,
  output logic              ovfFlag
);
  tmr_strobe_t strobe;
  logic srcSel, edgeSel;
  logic [WIDTH-1:0] count;

  tmr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cycleEn(cycleEn), .extPin(extPin),
    .gpioMode(gpioMode), .busWrEn(busWrEn), .busAddr(busAddr),
    .ctrlBits(busWrData[1:0]), .strobe(strobe),
    .srcSel(srcSel), .edgeSel(edgeSel)
  );

  tmr_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadVal(busWrData),
    .count(count), .ovfFlag(ovfFlag)
  );

  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADDR_COUNT: busRdData = count;
      ADDR_CTRL:  busRdData[1:0] = {edgeSel, srcSel};
      ADDR_STAT:  busRdData[0] = ovfFlag;
      default:    busRdData = '0;
    endcase
  end
endmodule

// File: tb/sel_edge_timer_test.sv
module sel_edge_timer_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cycleEn = 1'b0, extPin = 1'b0, gpioMode = 1'b0, busWrEn = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWrData = 8'd0;
  logic [7:0] busRdData;
  logic ovfFlag;
  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  sel_edge_timer uut (
    .clk(clk), .rstN(rstN), .cycleEn(cycleEn), .extPin(extPin),
    .gpioMode(gpioMode), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .ovfFlag(ovfFlag)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = 8'd0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic strobe(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cycleEn = 1'b1;
      @(negedge clk); cycleEn = 1'b0;
    end
  endtask

  task automatic setPin(input logic v);
    @(negedge clk); extPin = v;
    idle(4);
  endtask

  task automatic testReset;
    logic [7:0] d;
    busRead(2'd0, d); check("R1 count", d, 8'h00);
    busRead(2'd1, d); check("R1 ctrl", d, 8'h00);
    busRead(2'd2, d); check("R1 flag", d, 8'h00);
    check("R1 ovfFlag pin", {7'd0, ovfFlag}, 8'h00);
  endtask

  task automatic testInternal;
    logic [7:0] d;
    strobe(3);
    busRead(2'd0, d); check("R2 three strobes", d, 8'h03);
    idle(5);
    busRead(2'd0, d); check("R2 hold without strobe", d, 8'h03);
  endtask

  task automatic testCtrlReg;
    logic [7:0] d;
    busWrite(2'd1, 8'hFC);
    busRead(2'd1, d); check("R9 upper bits dropped", d, 8'h00);
    busRead(2'd3, d); check("R9 unused address", d, 8'h00);
  endtask

  task automatic testWrite;
    logic [7:0] d;
    busWrite(2'd0, 8'h5A);
    busRead(2'd0, d); check("R6 readback", d, 8'h5A);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = 2'd0; busWrData = 8'h10; cycleEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = 8'd0; cycleEn = 1'b0;
    busRead(2'd0, d); check("R6 write beats increment", d, 8'h10);
  endtask

  task automatic testRising;
    logic [7:0] d;
    busWrite(2'd0, 8'h20);
    busWrite(2'd1, 8'h01);
    setPin(1'b1);
    busRead(2'd0, d); check("R5 no count without strobe", d, 8'h20);
    strobe(1);
    busRead(2'd0, d); check("R3 rising counted", d, 8'h21);
    setPin(1'b0);
    strobe(1);
    busRead(2'd0, d); check("R3 falling ignored", d, 8'h21);
    setPin(1'b1); setPin(1'b0); setPin(1'b1);
    strobe(1);
    busRead(2'd0, d); check("R5 two edges one count", d, 8'h22);
    strobe(1);
    busRead(2'd0, d); check("R5 no extra count", d, 8'h22);
  endtask

  task automatic testFalling;
    logic [7:0] d;
    busWrite(2'd1, 8'h03);
    setPin(1'b0);
    strobe(1);
    busRead(2'd0, d); check("R4 falling counted", d, 8'h23);
    setPin(1'b1);
    strobe(1);
    busRead(2'd0, d); check("R4 rising ignored", d, 8'h23);
  endtask

  task automatic testGpio;
    logic [7:0] d;
    busWrite(2'd1, 8'h01);
    @(negedge clk); gpioMode = 1'b1;
    setPin(1'b0); setPin(1'b1);
    busRead(2'd0, d); check("R8 pin ignored", d, 8'h23);
    strobe(2);
    busRead(2'd0, d); check("R8 internal source forced", d, 8'h25);
    @(negedge clk); gpioMode = 1'b0;
    busWrite(2'd1, 8'h00);
  endtask

  task automatic testWrap;
    logic [7:0] d;
    busWrite(2'd0, 8'hFF);
    busRead(2'd2, d); check("R7 no flag on write", d, 8'h00);
    strobe(1);
    busRead(2'd0, d); check("R7 wrapped value", d, 8'h00);
    busRead(2'd2, d); check("R7 flag set", d, 8'h01);
    strobe(1);
    check("R7 flag sticky", {7'd0, ovfFlag}, 8'h01);
    busWrite(2'd2, 8'h00);
    busRead(2'd2, d); check("R7 zero write keeps flag", d, 8'h01);
    busWrite(2'd2, 8'h01);
    busRead(2'd2, d); check("R7 flag cleared", d, 8'h00);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    testReset();
    testInternal();
    testCtrlReg();
    testWrite();
    testRising();
    testFalling();
    testGpio();
    testWrap();
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #2000000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule